// File: doc/BRIEF.md
# Fully Associative Tag Lookup with Rotating Victim Pointer

This block is the tag side of a fully associative cache with 64 entries of 32-byte blocks. A lookup presents a 32-bit byte address. The five low bits select a byte within the block and play no part in matching. The remaining 27 bits form the tag. That tag is compared in one cycle against every valid stored tag. One clock later the block reports hit or miss, and on a hit it also reports the binary number of the matching entry. Block data and the refill sequence belong to the surrounding cache and are not modelled here.

Victim selection uses one rotating pointer, which is shown on `victim_idx` at all times. The pointer steps to the next entry when a lookup hits the entry it designates, or when a new tag is installed there. A hit on any other entry, or a miss, leaves it where it is. Entries that are used often therefore tend to push the pointer past themselves. This gives a cheap approximation of least-recently-used. After a miss, the surrounding controller installs the new tag through the fill port, and the tag goes into the entry the pointer designates.

Top module: `fa_tag_lookup`

## Requirements
- R1: While `rst` is high, and after it is released, no entry is valid, `victim_idx` is 0, and `rsp_valid` and `hit` are 0.
- R2: A lookup strobe (`lk_valid` high) in cycle t gives `rsp_valid` high in cycle t+1, with `hit` and `hit_idx` describing the store as it stood in cycle t.
- R3: The tag is address bits [31:5]. Bits [4:0] do not affect matching. Two addresses that differ only in bit 5 have different tags.
- R4: `hit` is 1 when some valid entry holds the lookup tag. `hit_idx` is then the entry number in binary, from 0 to 63.
- R5: An entry that has never been filled since reset never produces a hit.
- R6: A lookup that hits the entry `victim_idx` shows moves `victim_idx` to the next entry in the cycle after the strobe.
- R7: A lookup that misses, or that hits an entry other than the one `victim_idx` shows, leaves `victim_idx` unchanged.
- R8: A fill strobe (`fill_valid` high) writes tag bits [31:5] of `fill_addr` into the entry `victim_idx` shows and marks it valid. The pointer moves to the next entry. Lookups from the next cycle on see the new tag, and they no longer see the tag it replaced.
- R9: The pointer moves from entry 63 to entry 0, whether it is moved by a fill or by a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup strobe |
| lk_addr | input | 32 | Byte address to look up |
| fill_valid | input | 1 | Install strobe |
| fill_addr | input | 32 | Byte address of the block being installed |
| rsp_valid | output | 1 | Lookup result valid (one cycle after the strobe) |
| hit | output | 1 | Lookup found a matching valid entry |
| hit_idx | output | 6 | Number of the matching entry, meaningful only when hit is 1 |
| victim_idx | output | 6 | Entry the replacement pointer designates |

## Verification
The assertions take for granted that no two valid entries ever hold the same tag. They also assume that a lookup and a fill are never strobed in the same cycle. The stimulus stays within both assumptions in two ways. It installs a tag only after a lookup of that tag has missed, or when the tag has never been used. It drives each strobe alone, for a single cycle, with idle cycles between strobes. Tag values are spaced so that flipping address bit 5 of a stored tag gives a tag that was never installed. This lets the byte-offset and tag-boundary cases miss without adding duplicates.

// File: rtl/fa_tag_pkg.sv
package fa_tag_pkg;
  localparam int unsigned DEF_ADDR_W  = 32;
  localparam int unsigned DEF_OFS_W   = 5;
  localparam int unsigned DEF_ENTRIES = 64;
endpackage

// File: rtl/fa_cam_entry.sv
module fa_cam_entry #(
  parameter int unsigned TAG_W = 27
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [TAG_W-1:0] cmp_tag,
  output logic             match
);
  logic             vld_q;
  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
    end else if (wr_en) begin
      vld_q <= 1'b1;
    end
    if (wr_en) tag_q <= wr_tag;
  end

  assign match = vld_q && (tag_q == cmp_tag);

  // R8
  fill_visible_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (vld_q && tag_q == $past(wr_tag)));
endmodule

// File: rtl/fa_onehot_enc.sv
module fa_onehot_enc #(
  parameter int unsigned N = 64,
  parameter int unsigned W = 6
) (
  input  logic [N-1:0] onehot,
  output logic [W-1:0] bin
);
  always_comb begin
    bin = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot[i]) bin = bin | W'(i);
    end
  end
endmodule

// File: rtl/fa_repl_ptr.sv
module fa_repl_ptr #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned IDX_W   = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (advance) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

  // R9
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    advance |=> (ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1)));

  // R7
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(ptr));
endmodule

// File: rtl/fa_tag_lookup.sv
module fa_tag_lookup #(
  parameter int unsigned ADDR_W  = fa_tag_pkg::DEF_ADDR_W,
  parameter int unsigned OFS_W   = fa_tag_pkg::DEF_OFS_W,
  parameter int unsigned ENTRIES = fa_tag_pkg::DEF_ENTRIES,
  localparam int unsigned TAG_W  = ADDR_W - OFS_W,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  output logic              rsp_valid,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx,
  output logic [IDX_W-1:0]  victim_idx
);
  logic [TAG_W-1:0]   lk_tag;
  logic [TAG_W-1:0]   fill_tag;
  logic [ENTRIES-1:0] match_vec;
  logic [IDX_W-1:0]   match_idx;
  logic               any_match;
  logic               ptr_hit;
  logic               advance;

  assign lk_tag   = lk_addr[ADDR_W-1:OFS_W];
  assign fill_tag = fill_addr[ADDR_W-1:OFS_W];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    fa_cam_entry #(.TAG_W(TAG_W)) i_entry (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (fill_valid && (victim_idx == IDX_W'(e))),
      .wr_tag  (fill_tag),
      .cmp_tag (lk_tag),
      .match   (match_vec[e])
    );
  end

  fa_onehot_enc #(.N(ENTRIES), .W(IDX_W)) i_enc (
    .onehot (match_vec),
    .bin    (match_idx)
  );

  assign any_match = |match_vec;
  assign ptr_hit   = lk_valid && any_match && (match_idx == victim_idx);
  assign advance   = fill_valid || ptr_hit;

  fa_repl_ptr #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) i_ptr (
    .clk     (clk),
    .rst     (rst),
    .advance (advance),
    .ptr     (victim_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      hit       <= 1'b0;
      hit_idx   <= '0;
    end else begin
      rsp_valid <= lk_valid;
      if (lk_valid) begin
        hit     <= any_match;
        hit_idx <= match_idx;
      end
    end
  end

  // R2
  rsp_timing_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);

  // R4
  unique_match_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid |-> $onehot0(match_vec));

  // R6
  hit_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !fill_valid && any_match && match_idx == victim_idx)
      |=> (hit && hit_idx != victim_idx));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (!rsp_valid && !hit && victim_idx == '0));
endmodule

// File: tb/test_fa_tag_lookup.sv
module test_fa_tag_lookup;
  localparam int CLK_PERIOD = 10;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        fill_valid = 1'b0;
  logic [31:0] fill_addr = '0;
  logic        rsp_valid, hit;
  logic [5:0]  hit_idx, victim_idx;

  fa_tag_lookup i_fa_tag_lookup (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .rsp_valid(rsp_valid),
    .hit(hit), .hit_idx(hit_idx), .victim_idx(victim_idx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { bit hit; int idx; int vic; string req; } exp_t;
  exp_t sb[$];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [26:0] m_tag [N];
  bit          m_vld [N];
  int          m_ptr;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) m_vld[i] = 0;
    m_ptr = 0;
  endtask

  task automatic lookup(input logic [31:0] a, input string req);
    exp_t e;
    e.hit = 0; e.idx = 0; e.req = req;
    for (int i = 0; i < N; i++) begin
      if (m_vld[i] && m_tag[i] == a[31:5]) begin e.hit = 1; e.idx = i; end
    end
    if (e.hit && e.idx == m_ptr) m_ptr = (m_ptr + 1) % N;
    e.vic = m_ptr;
    sb.push_back(e);
    @(negedge clk); lk_valid = 1'b1; lk_addr = a;
    @(negedge clk); lk_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic fill(input logic [31:0] a, input string req);
    @(negedge clk); fill_valid = 1'b1; fill_addr = a;
    m_tag[m_ptr] = a[31:5]; m_vld[m_ptr] = 1; m_ptr = (m_ptr + 1) % N;
    @(negedge clk); fill_valid = 1'b0;
    chk(victim_idx == 6'(m_ptr), req, "victim after fill", victim_idx, m_ptr);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (sb.size() == 0) begin
        chk(0, "R2", "unexpected response", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(hit == e.hit, e.req, "hit", hit, e.hit);
        if (e.hit) chk(hit_idx == 6'(e.idx), e.req, "hit_idx", hit_idx, e.idx);
        chk(victim_idx == 6'(e.vic), e.req, "victim_idx", victim_idx, e.vic);
      end
    end
  end

  function automatic logic [31:0] addr_of(int tag, int ofs);
    return {27'(tag), 5'(ofs)};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(victim_idx == 0, "R1", "victim in reset", victim_idx, 0);
    chk(rsp_valid == 0, "R1", "rsp_valid in reset", rsp_valid, 0);
    chk(hit == 0, "R1", "hit in reset", hit, 0);
    rst = 1'b0;
    @(negedge clk);
    // R5: empty store misses
    lookup(32'h0000_1234, "R5");
    // R8/R9: install 64 tags, pointer wraps back to 0
    for (int i = 0; i < N; i++) fill(addr_of(100 + 8*i, i % 32), "R8");
    chk(victim_idx == 0, "R9", "pointer wrap after fills", victim_idx, 0);
    // R3/R4/R7: hit entry 5 with other offset, pointer stays
    lookup(addr_of(100 + 8*5, 31), "R4");
    lookup(addr_of(100 + 8*5, 0), "R7");
    // R6: hit the pointed entry
    lookup(addr_of(100, 17), "R6");
    // R3: bit 5 flipped gives another tag -> miss, pointer held
    lookup(addr_of(101, 0), "R3");
    // R7 miss with new tag, then install it
    lookup(addr_of(5000, 3), "R7");
    fill(addr_of(5000, 9), "R8");
    lookup(addr_of(108, 0), "R8");
    lookup(addr_of(5000, 30), "R4");
    // R6/R9: walk pointer via hits through 63 and wrap
    for (int e = 2; e < N; e++) lookup(addr_of(100 + 8*e, e % 32), "R6");
    chk(victim_idx == 0, "R9", "pointer wrap after hits", victim_idx, 0);
    lookup(addr_of(100, 1), "R9");
    // R1: reset mid run clears entries and pointer
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(victim_idx == 0, "R1", "victim after reset", victim_idx, 0);
    rst = 1'b0;
    model_reset();
    lookup(addr_of(5000, 0), "R1");
    lookup(addr_of(100 + 8*7, 0), "R5");
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R2", "responses outstanding", sb.size(), 0);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule